// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and a frame parser. Each sampled bus bit arrives with a strobe. The block recognises the stuff bits that a transmitter inserts after five equal bits, and drops them. Every real frame bit goes out in the same cycle as its input strobe, together with its position in the frame. Start of frame is position 0, and stuff bits do not count toward the position.

The block keeps a run history over the raw bit stream. A stuff bit counts as the first bit of a new run, so an inserted bit can itself contribute to a later stuff condition. The parser drives an enable low once it reaches the fixed-form trailer of the frame, which starts after the CRC sequence. While the enable is low, every bit is forwarded unchanged.

A pulse marks each discarded stuff bit. A second pulse marks a sixth equal bit while detection is on. A strobe on the frame-start input clears the counters and the run history. If a bit arrives in that same cycle, it is taken as bit 0 of the new frame.

Top module: `can_destuffer`

## Requirements
- R1: A stuff bit is detected when stuff_en is high, the five raw bits before it in the current frame are equal, and the new bit differs from them. In that case stuff_bit pulses in the cycle of its in_valid strobe and out_valid stays low.
- R2: Every bit that is not a stuff bit is forwarded in the cycle of its strobe, with out_valid high and out_bit equal to in_bit. out_index equals the number of frame bits already forwarded in this frame, so start of frame is index 0.
- R3: A discarded stuff bit stays in the run history and begins a new run of length one. For example, after 0,0,0,0,0 and a stuff 1, four further 1s followed by a 0 make that 0 a stuff bit.
- R4: raw_count shows the number of raw bits accepted so far in the frame, stuff bits included. A stuff bit advances raw_count but leaves out_index unchanged.
- R5: While stuff_en is low, no bit is discarded and stuff_error stays low, whatever the preceding run.
- R6: With stuff_en high, a sixth equal bit raises stuff_error for the cycle of its strobe. That bit is still forwarded with out_valid high.
- R7: frame_start clears out_index, raw_count and the run history. A bit presented in the same cycle is treated as bit 0 of the new frame, with no history before it.
- R8: After reset, out_valid, stuff_bit, stuff_error, out_index and raw_count are all zero.
- R9: In a cycle without in_valid, no output pulse occurs, and out_index and raw_count keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears counters and run history; a bit in the same cycle is frame bit 0 |
| stuff_en | input | 1 | Stuff detection enable, driven low by the parser for the trailer |
| in_valid | input | 1 | Strobe for one sampled raw bit |
| in_bit | input | 1 | Sampled raw bit value |
| out_valid | output | 1 | Strobe for a forwarded frame bit |
| out_bit | output | 1 | Forwarded frame bit value |
| out_index | output | CNT_W | Frame-bit index of the current bit, with stuff bits excluded |
| raw_count | output | CNT_W | Number of raw bits accepted earlier in this frame |
| stuff_bit | output | 1 | Pulse for a discarded stuff bit |
| stuff_error | output | 1 | Pulse for a sixth equal bit while detection is on |

## Verification
On every cycle the assertions check the following:
- A stuff bit is never forwarded.
- Two stuff bits never follow each other.
- out_index advances by one after each forwarded bit and holds after a stuff bit.
- raw_count advances by one after every accepted bit.
- A low enable suppresses both pulses.

Only the directed scenarios show whether detection fires at exactly the right position. They cover a run that a stuff bit itself helps to build, the error on a sixth equal bit, and the history being discarded when a frame start interrupts a run.

// File: rtl/can_destuffer.sv
module can_destuffer #(
  parameter int CNT_W   = 8,
  parameter int RUN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             stuff_en,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             out_valid,
  output logic             out_bit,
  output logic [CNT_W-1:0] out_index,
  output logic [CNT_W-1:0] raw_count,
  output logic             stuff_bit,
  output logic             stuff_error
);
  localparam int RUN_MAX = RUN_LEN + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q, run_eff, run_nxt;
  logic             last_q;
  logic [CNT_W-1:0] idx_q, raw_q;
  logic             long_run, same;

  assign run_eff   = frame_start ? '0 : run_q;
  assign out_index = frame_start ? '0 : idx_q;
  assign raw_count = frame_start ? '0 : raw_q;

  assign same     = (run_eff != '0) && (in_bit == last_q);
  assign long_run = run_eff >= RUN_W'(RUN_LEN);

  assign stuff_bit   = in_valid & stuff_en & long_run & ~same;
  assign stuff_error = in_valid & stuff_en & long_run & same;
  assign out_valid   = in_valid & ~stuff_bit;
  assign out_bit     = in_bit;

  always_comb begin
    if (!same)                         run_nxt = RUN_W'(1);
    else if (run_eff == RUN_W'(RUN_MAX)) run_nxt = run_eff;
    else                               run_nxt = run_eff + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
      idx_q  <= '0;
      raw_q  <= '0;
    end else if (in_valid) begin
      run_q  <= run_nxt;
      last_q <= in_bit;
      raw_q  <= raw_count + CNT_W'(1);
      idx_q  <= stuff_bit ? out_index : out_index + CNT_W'(1);
    end else if (frame_start) begin
      run_q <= '0;
      idx_q <= '0;
      raw_q <= '0;
    end
  end
endmodule

// File: rtl/can_destuffer_chk.sv
module can_destuffer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             stuff_en,
  input logic             in_valid,
  input logic             in_bit,
  input logic             out_valid,
  input logic             out_bit,
  input logic [CNT_W-1:0] out_index,
  input logic [CNT_W-1:0] raw_count,
  input logic             stuff_bit,
  input logic             stuff_error
);
  p_stuff_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_bit |-> !out_valid);

  p_no_back_to_back_stuff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_bit |=> !stuff_bit);

  p_forward_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && out_bit == in_bit));

  p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (frame_start || out_index == $past(out_index) + CNT_W'(1)));

  p_index_hold_on_stuff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_bit |=> (frame_start || out_index == $past(out_index)));

  p_raw_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (frame_start || raw_count == $past(raw_count) + CNT_W'(1)));

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stuff_en |-> (!stuff_bit && !stuff_error));

  p_error_forwarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_error |-> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !frame_start) |=> (frame_start || (out_index == $past(out_index)
      && raw_count == $past(raw_count))));

  p_idle_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!out_valid && !stuff_bit && !stuff_error));
endmodule

bind can_destuffer can_destuffer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .stuff_en(stuff_en),
  .in_valid(in_valid), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
  .out_index(out_index), .raw_count(raw_count), .stuff_bit(stuff_bit),
  .stuff_error(stuff_error)
);

// File: tb/can_destuffer_tb.sv
module can_destuffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, stuff_en = 1'b1, in_valid = 1'b0, in_bit = 1'b0;
  logic out_valid, out_bit, stuff_bit, stuff_error;
  logic [CNT_W-1:0] out_index, raw_count;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_destuffer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .stuff_en(stuff_en),
    .in_valid(in_valid), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
    .out_index(out_index), .raw_count(raw_count), .stuff_bit(stuff_bit),
    .stuff_error(stuff_error)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input string req, input logic b, input logic fs, input logic en,
                      input logic e_stuff, input logic e_err, input int e_idx);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; frame_start = fs; stuff_en = en;
    #1;
    check(req, "stuff_bit", stuff_bit, e_stuff);
    check(req, "out_valid", out_valid, !e_stuff);
    check(req, "stuff_error", stuff_error, e_err);
    check(req, "out_index", out_index, e_idx);
    if (!e_stuff) check(req, "out_bit", out_bit, b);
    @(posedge clk);
    #1;
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    check("R8", "out_valid", out_valid, 0);
    check("R8", "stuff_bit", stuff_bit, 0);
    check("R8", "stuff_error", stuff_error, 0);
    check("R8", "out_index", out_index, 0);
    check("R8", "raw_count", raw_count, 0);
  endtask

  task automatic test_basic_stuff();
    send("R7", 1'b0, 1'b1, 1'b1, 0, 0, 0);
    for (int i = 1; i < 5; i++) send("R2", 1'b0, 1'b0, 1'b1, 0, 0, i);
    send("R1", 1'b1, 1'b0, 1'b1, 1, 0, 5);
    send("R2", 1'b1, 1'b0, 1'b1, 0, 0, 5);
    #1 check("R4", "raw_count", raw_count, 7);
    check("R4", "out_index", out_index, 6);
  endtask

  task automatic test_stuff_in_run();
    for (int i = 6; i < 9; i++) send("R3", 1'b1, 1'b0, 1'b1, 0, 0, i);
    send("R3", 1'b0, 1'b0, 1'b1, 1, 0, 9);
    #1 check("R4", "raw_count", raw_count, 11);
  endtask

  task automatic test_error();
    send("R7", 1'b1, 1'b1, 1'b1, 0, 0, 0);
    for (int i = 1; i < 5; i++) send("R6", 1'b1, 1'b0, 1'b1, 0, 0, i);
    send("R6", 1'b1, 1'b0, 1'b1, 0, 1, 5);
    send("R1", 1'b0, 1'b0, 1'b1, 1, 0, 6);
  endtask

  task automatic test_disabled();
    send("R5", 1'b0, 1'b1, 1'b0, 0, 0, 0);
    for (int i = 1; i < 6; i++) send("R5", 1'b0, 1'b0, 1'b0, 0, 0, i);
    send("R5", 1'b1, 1'b0, 1'b0, 0, 0, 6);
  endtask

  task automatic test_restart();
    send("R7", 1'b0, 1'b1, 1'b1, 0, 0, 0);
    for (int i = 1; i < 5; i++) send("R7", 1'b0, 1'b0, 1'b1, 0, 0, i);
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; frame_start = 1'b1; stuff_en = 1'b1;
    #1;
    check("R7", "raw_count", raw_count, 0);
    check("R7", "stuff_bit", stuff_bit, 0);
    check("R7", "out_index", out_index, 0);
    @(posedge clk);
    #1 in_valid = 1'b0; frame_start = 1'b0;
    #1 check("R7", "raw_count", raw_count, 1);
  endtask

  task automatic test_idle();
    logic [CNT_W-1:0] idx0, raw0;
    idx0 = out_index; raw0 = raw_count;
    repeat (3) @(negedge clk);
    #1;
    check("R9", "out_valid", out_valid, 0);
    check("R9", "stuff_bit", stuff_bit, 0);
    check("R9", "out_index", out_index, idx0);
    check("R9", "raw_count", raw_count, raw0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2);
    test_reset();
    @(negedge clk) rst_n = 1'b1;
    test_basic_stuff();
    test_stuff_in_run();
    test_error();
    test_disabled();
    test_restart();
    test_idle();
    finish_run();
  end
endmodule